// File: doc/BRIEF.md
# Interrupt Event Latch and Mask Controller

This block collects one-cycle event pulses from a multi-context transfer engine and turns them into a single level interrupt. Each pulse sets a sticky bit in a raw status vector, whether or not that event is enabled. A mask gates the raw vector into an enabled status view. The OR of the enabled view, held in a small two-state line machine, drives the interrupt pin. The block does not detect any events. It only latches them, masks them and clears them.

Software reaches the block through a four-entry register port. Two views show status: the raw view and the enabled view. Two strobes change the mask: a write-1-to-enable strobe and a write-1-to-disable strobe. Both mask strobes read back the same mask. Writing ones to the raw view injects events for debug. Writing ones to the enabled view clears the matching raw bits, including bits whose events are masked.

The line machine has two states. LINE_QUIET moves to LINE_RAISED on the transition "pending": at least one enabled status bit is set. LINE_RAISED moves back to LINE_QUIET on the transition "drained": no enabled status bit is set. Each state holds when its leaving condition is false.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the raw status, the enable mask and the `irq_o` output are all 0.
- R2: An event pulse sets its raw status bit on the next clock edge, even when that event is masked.
- R3: A write to address 0 (raw view) sets every raw bit that is 1 in the write data. Bits that are 0 in the write data keep their value.
- R4: A read of address 1 (enabled view) returns the raw status ANDed with the enable mask.
- R5: A write to address 1 clears every raw bit that is 1 in the write data, including bits whose events are masked.
- R6: A write to address 2 sets the mask bits that are 1 in the write data. A write to address 3 clears them. Reads of address 2 and address 3 both return the current mask.
- R7: Bit positions are fixed. Bit 0 is the bus error. Bit 1 is the global invalid address. Bits 8+c are done for context c. Bits 16+c are invalid access for context c. Bits 24+c are underrun for context c, with c from 0 to 3. Every other bit reads 0 in all four views, and writes to those bits have no effect.
- R8: `irq_o` is registered. One clock edge after the enabled status is nonzero it is 1, and one clock edge after the enabled status is zero it is 0.
- R9: When an event pulse and a write-1-to-clear to address 1 hit the same bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 raw, 1 enabled, 2 mask set, 3 mask clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ev_bus_err | input | 1 | Bus error response pulse |
| ev_glob_inv | input | 1 | Global invalid address pulse |
| ev_done | input | 4 | Per-context done pulses |
| ev_inv | input | 4 | Per-context invalid access pulses |
| ev_udr | input | 4 | Per-context underrun pulses |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled at the clock edge, and that `reg_addr` and `reg_wdata` are stable whenever `reg_we` is high. The stimulus drives every input on the falling edge and returns every pulse to 0 after one cycle, so each write or event lands on exactly one rising edge. Collisions are created on purpose, so that an event and a clear hit the same bit in one cycle. Writes with every bit set exercise the reserved bit positions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_W    = 32;
    localparam int GRP_W    = 8;
    localparam int BIT_BUS  = 0;
    localparam int BIT_GINV = 1;
    localparam int DONE_LSB = 8;
    localparam int INV_LSB  = 16;
    localparam int UDR_LSB  = 24;

    typedef enum logic [1:0] {
        RA_RAW    = 2'd0,
        RA_ENSTAT = 2'd1,
        RA_MSET   = 2'd2,
        RA_MCLR   = 2'd3
    } reg_addr_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

    // Mask of implemented bit positions for a given number of contexts.
    function automatic logic [REG_W-1:0] implemented_bits(input int nctx);
        logic [REG_W-1:0] m;
        m = '0;
        m[BIT_BUS]  = 1'b1;
        m[BIT_GINV] = 1'b1;
        for (int c = 0; c < nctx; c++) begin
            m[DONE_LSB + c] = 1'b1;
            m[INV_LSB + c]  = 1'b1;
            m[UDR_LSB + c]  = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irqc_event_map.sv
module irqc_event_map
    import irqc_pkg::*;
#(
    parameter int NCTX = 4
) (
    input  logic             ev_bus_err,
    input  logic             ev_glob_inv,
    input  logic [NCTX-1:0]  ev_done,
    input  logic [NCTX-1:0]  ev_inv,
    input  logic [NCTX-1:0]  ev_udr,
    output logic [REG_W-1:0] ev_vec
);

    // Place each pulse at its fixed bit position in the status word.
    always_comb begin
        ev_vec           = '0;
        ev_vec[BIT_BUS]  = ev_bus_err;
        ev_vec[BIT_GINV] = ev_glob_inv;
        for (int c = 0; c < NCTX; c++) begin
            ev_vec[DONE_LSB + c] = ev_done[c];
            ev_vec[INV_LSB + c]  = ev_inv[c];
            ev_vec[UDR_LSB + c]  = ev_udr[c];
        end
    end

endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank
    import irqc_pkg::*;
#(
    parameter int NCTX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] ev_vec,
    input  logic             we,
    input  reg_addr_e        addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] raw_q,
    output logic [REG_W-1:0] mask_q
);

    localparam logic [REG_W-1:0] IMPL = implemented_bits(NCTX);

    logic             wr_raw, wr_enstat, wr_mset, wr_mclr;
    logic [REG_W-1:0] wd_impl;
    logic [REG_W-1:0] raw_d, mask_d;

    assign wd_impl   = wdata & IMPL;
    assign wr_raw    = we && (addr == RA_RAW);
    assign wr_enstat = we && (addr == RA_ENSTAT);
    assign wr_mset   = we && (addr == RA_MSET);
    assign wr_mclr   = we && (addr == RA_MCLR);

    // Clear first, then OR in events and injections, so an event wins a collision.
    always_comb begin
        raw_d = raw_q;
        if (wr_enstat) raw_d = raw_d & ~wd_impl;
        if (wr_raw)    raw_d = raw_d | wd_impl;
        raw_d = raw_d | (ev_vec & IMPL);
    end

    always_comb begin
        mask_d = mask_q;
        if (wr_mset) mask_d = mask_q | wd_impl;
        if (wr_mclr) mask_d = mask_q & ~wd_impl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q  <= raw_d;
            mask_q <= mask_d;
        end
    end

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_vec & IMPL) != '0) |=> ((raw_q & $past(ev_vec & IMPL)) == $past(ev_vec & IMPL))); // R2
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enstat && ((ev_vec & wdata & IMPL) != '0)) |=> ((raw_q & $past(ev_vec & wdata & IMPL)) != '0)); // R9
    AST_W1S_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_raw |=> ((raw_q & $past(wdata & IMPL)) == $past(wdata & IMPL))); // R3
    AST_W1C_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enstat |=> ((raw_q & $past(wdata & ~ev_vec & IMPL)) == '0)); // R5
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask_q & $past(wdata & IMPL)) == $past(wdata & IMPL))); // R6
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask_q & $past(wdata & IMPL)) == '0)); // R6
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (((raw_q | mask_q) & ~IMPL) == '0)); // R7

endmodule

// File: rtl/irqc_line_fsm.sv
module irqc_line_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq_o
);

    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending)  state_d = LINE_RAISED;
            LINE_RAISED: if (!pending) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end

    AST_LINE_UP: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq_o); // R8
    AST_LINE_DN: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq_o); // R8

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irqc_pkg::*;
#(
    parameter int NCTX = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_bus_err,
    input  logic              ev_glob_inv,
    input  logic [NCTX-1:0]   ev_done,
    input  logic [NCTX-1:0]   ev_inv,
    input  logic [NCTX-1:0]   ev_udr,
    output logic              irq_o
);

    logic [REG_W-1:0] ev_vec, raw_q, mask_q, en_stat;
    reg_addr_e        addr_e;

    assign addr_e  = reg_addr_e'(reg_addr);
    assign en_stat = raw_q & mask_q;

    irqc_event_map #(.NCTX(NCTX)) u_map (
        .ev_bus_err  (ev_bus_err),
        .ev_glob_inv (ev_glob_inv),
        .ev_done     (ev_done),
        .ev_inv      (ev_inv),
        .ev_udr      (ev_udr),
        .ev_vec      (ev_vec)
    );

    irqc_status_bank #(.NCTX(NCTX)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_vec (ev_vec),
        .we     (reg_we),
        .addr   (addr_e),
        .wdata  (reg_wdata),
        .raw_q  (raw_q),
        .mask_q (mask_q)
    );

    irqc_line_fsm u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|en_stat),
        .irq_o   (irq_o)
    );

    always_comb begin
        unique case (addr_e)
            RA_RAW:    reg_rdata = raw_q;
            RA_ENSTAT: reg_rdata = en_stat;
            RA_MSET:   reg_rdata = mask_q;
            RA_MCLR:   reg_rdata = mask_q;
            default:   reg_rdata = '0;
        endcase
    end

    AST_ENSTAT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_e == RA_ENSTAT) |-> ((reg_rdata & ~mask_q) == '0)); // R4

endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_bus_err = 1'b0, ev_glob_inv = 1'b0;
    logic [3:0]  ev_done = '0, ev_inv = '0, ev_udr = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Behavioural reference state
    logic [31:0] m_raw = '0, m_mask = '0;
    logic        m_irq = 1'b0;
    logic [31:0] cur_ev = '0;
    localparam logic [31:0] IMPL_BITS = 32'h0F0F_0F03;

    always #5 clk = ~clk;

    irq_status_ctrl i_irq_status_ctrl (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .ev_bus_err, .ev_glob_inv, .ev_done, .ev_inv, .ev_udr, .irq_o
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Reference model, evaluated on each rising edge from the inputs of the cycle.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_raw = '0; m_mask = '0; m_irq = 1'b0;
        end else begin
            logic [31:0] d;
            m_irq = |(m_raw & m_mask);
            d = reg_wdata & IMPL_BITS;
            if (reg_we && reg_addr == 2'd1) m_raw = m_raw & ~d;
            if (reg_we && reg_addr == 2'd0) m_raw = m_raw | d;
            m_raw = m_raw | (cur_ev & IMPL_BITS);
            if (reg_we && reg_addr == 2'd2) m_mask = m_mask | d;
            if (reg_we && reg_addr == 2'd3) m_mask = m_mask & ~d;
        end
    end

    // Interrupt compared against the model on every cycle.
    always @(negedge clk) if (rst_n && !finished) chk("R8 irq_o", {31'd0, irq_o}, {31'd0, m_irq});

    task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d, input logic [31:0] ev);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; cur_ev = ev;
        ev_bus_err = ev[0]; ev_glob_inv = ev[1];
        ev_done = ev[11:8]; ev_inv = ev[19:16]; ev_udr = ev[27:24];
    endtask

    task automatic idle();
        cyc(1'b0, 2'd0, '0, '0);
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_we = 1'b0; cur_ev = '0; reg_addr = a;
        ev_bus_err = 1'b0; ev_glob_inv = 1'b0; ev_done = '0; ev_inv = '0; ev_udr = '0;
        #1;
        chk(tag, reg_rdata, exp);
        chk({tag, " model"}, exp, (a == 2'd0) ? m_raw : (a == 2'd1) ? (m_raw & m_mask) : m_mask);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, 32'h0, "R1 raw after reset");
        rd(2'd1, 32'h0, "R1 enabled after reset");
        rd(2'd2, 32'h0, "R1 mask after reset");
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        // R2: masked event still latches
        cyc(1'b0, 2'd0, '0, 32'h0000_0400); idle();
        rd(2'd0, 32'h0000_0400, "R2 masked done ctx2 latched");
        rd(2'd1, 32'h0, "R4 masked bit not pending");
        // R6: enable and read back from both strobes
        cyc(1'b1, 2'd2, 32'h0000_0400, '0); idle();
        rd(2'd2, 32'h0000_0400, "R6 mask via set addr");
        rd(2'd3, 32'h0000_0400, "R6 mask via clear addr");
        rd(2'd1, 32'h0000_0400, "R4 enabled view");
        chk("R8 irq raised", {31'd0, irq_o}, 32'd1);
        // R5: clear through enabled view
        cyc(1'b1, 2'd1, 32'h0000_0400, '0); idle(); idle();
        rd(2'd0, 32'h0, "R5 raw cleared");
        chk("R8 irq dropped", {31'd0, irq_o}, 32'd0);
        // R3 and R7: inject with all ones, reserved bits stay 0
        cyc(1'b1, 2'd0, 32'hFFFF_FFFF, '0); idle();
        rd(2'd0, IMPL_BITS, "R7 R3 raw injection all ones");
        cyc(1'b1, 2'd0, 32'h0, '0); idle();
        rd(2'd0, IMPL_BITS, "R3 zero write no effect");
        // R6: clear mask, then set all ones
        cyc(1'b1, 2'd3, 32'h0000_0400, '0); idle();
        rd(2'd2, 32'h0, "R6 mask cleared");
        cyc(1'b1, 2'd2, 32'hFFFF_FFFF, '0); idle();
        rd(2'd3, IMPL_BITS, "R7 mask set all ones");
        rd(2'd1, IMPL_BITS, "R4 enabled all");
        // R5: clear a masked bit
        cyc(1'b1, 2'd3, 32'h0000_0001, '0); idle();
        cyc(1'b1, 2'd1, 32'h0000_0001, '0); idle();
        rd(2'd0, IMPL_BITS & ~32'h1, "R5 masked bit cleared");
        // Clear everything
        cyc(1'b1, 2'd1, 32'hFFFF_FFFF, '0); idle(); idle();
        rd(2'd0, 32'h0, "R5 clear all");
        // R9: collision of event and clear
        cyc(1'b1, 2'd0, 32'h0300_0000, '0); idle();
        cyc(1'b1, 2'd1, 32'h0300_0000, 32'h0200_0000); idle();
        rd(2'd0, 32'h0200_0000, "R9 event wins over clear");
        // R7: bus error and global invalid positions, multi-event
        cyc(1'b0, 2'd0, '0, 32'h0001_0003); idle();
        rd(2'd0, 32'h0201_0003, "R7 global bits positions");
        rd(2'd1, 32'h0201_0002, "R4 masked bit0 hidden");
        // R8: drop irq via mask clear
        cyc(1'b1, 2'd3, 32'hFFFF_FFFF, '0); idle(); idle();
        chk("R8 irq after mask clear", {31'd0, irq_o}, 32'd0);
        repeat (3) idle();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule